// File: doc/BRIEF.md
# Sequential Unsigned Multiply/Divide Unit

This block takes two unsigned byte operands and, over a fixed run of iteration cycles, either multiplies them or divides the first by the second. The answer goes back into the two operand slots. A multiply returns the low half of the double-width product on the A result and the high half on the B result. A divide returns the quotient on the A result and the remainder on the B result. The unit is meant to sit next to an accumulator-style register file. That file supplies A and B with a single-cycle start pulse and writes both results back when the done pulse appears.

The datapath is one shared pair of shift registers. A multiply walks through them with shift-and-add steps, and a divide walks through them with restoring shift-subtract steps, one operand bit per clock. The overflow output marks a product that does not fit in one byte, or a divide by zero. The carry output is always cleared. When the divisor is zero, the unit hands back both operands unchanged, so the result is deterministic. The operand width is the parameter `W` and defaults to 8.

Top module: `mdu_seq`

## Requirements
- R1: After reset, res_a, res_b, carry, ovf and done are all 0.
- R2: With op_div = 0 (multiply), res_a holds the low W bits of opnd_a*opnd_b and res_b holds the high W bits.
- R3: A multiply drives ovf to 1 exactly when the product exceeds 2^W-1, and drives carry to 0.
- R4: With op_div = 1 and a nonzero divisor, res_a holds opnd_a/opnd_b and res_b holds opnd_a%opnd_b, with carry and ovf both 0.
- R5: A divide by a zero opnd_b drives ovf to 1 and carry to 0, and returns res_a = opnd_a and res_b = opnd_b, the values captured at start.
- R6: The rising edge that accepts start is followed by W more edges. done is high for exactly one cycle after the last of these, and the results are valid in that cycle.
- R7: A start pulse that arrives while an operation is running is ignored. It changes neither the results nor the done timing of the running operation, and it produces no extra done.
- R8: res_a, res_b and ovf hold their values after done until the next operation completes, whatever the inputs do in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, sampled only while idle |
| op_div | input | 1 | Operation select: 0 multiply, 1 divide |
| opnd_a | input | W | Operand A (multiplicand or dividend) |
| opnd_b | input | W | Operand B (multiplier or divisor) |
| res_a | output | W | New A: product low half or quotient |
| res_b | output | W | New B: product high half or remainder |
| carry | output | 1 | Carry flag, always 0 |
| ovf | output | 1 | Overflow: wide product or zero divisor |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checker watches every cycle. It checks that done is a single-cycle pulse that arrives exactly W edges after acceptance. It checks that the captured operands do not move when a start arrives mid-run. On every done, it checks the product against the captured operands, the overflow rules for both operations, and that the remainder is smaller than the divisor. Only the bench scenarios can show the following: the reset values, that a start arriving during a run causes no second completion, that results hold while the inputs change between operations, and the exact quotient values across the operand sweep.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
   typedef enum logic {
      MDU_MUL = 1'b0,
      MDU_DIV = 1'b1
   } mdu_op_e;
endpackage

// File: rtl/mdu_seq_ctrl.sv
module mdu_seq_ctrl #(
   parameter int W  = 8,
   localparam int CW = (W > 2) ? $clog2(W) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic accept,
   output logic step,
   output logic last,
   output logic busy,
   output logic done
);
   logic [CW-1:0] cnt_q;

   assign accept = start && !busy;
   assign step   = busy;
   assign last   = busy && (cnt_q == CW'(W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy  <= 1'b1;
            cnt_q <= '0;
         end else if (busy) begin
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/mdu_mul_step.sv
module mdu_mul_step #(
   parameter int W = 8
) (
   input  logic [W-1:0] hi,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] mcand,
   output logic [W-1:0] hi_n,
   output logic [W-1:0] lo_n
);
   logic [W:0] sum;

   always_comb begin
      sum  = {1'b0, hi} + (lo[0] ? {1'b0, mcand} : '0);
      hi_n = sum[W:1];
      lo_n = {sum[0], lo[W-1:1]};
   end
endmodule

// File: rtl/mdu_div_step.sv
module mdu_div_step #(
   parameter int W = 8
) (
   input  logic [W-1:0] rem,
   input  logic [W-1:0] quo,
   input  logic [W-1:0] dvsr,
   output logic [W-1:0] rem_n,
   output logic [W-1:0] quo_n
);
   logic [W:0]   trial;
   logic [W+1:0] diff;
   logic         fits;

   always_comb begin
      trial = {rem, quo[W-1]};
      diff  = {1'b0, trial} - {2'b00, dvsr};
      fits  = !diff[W+1];
      rem_n = fits ? diff[W-1:0] : trial[W-1:0];
      quo_n = {quo[W-2:0], fits};
   end
endmodule

// File: rtl/mdu_seq.sv
module mdu_seq
   import muldiv_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         op_div,
   input  logic [W-1:0] opnd_a,
   input  logic [W-1:0] opnd_b,
   output logic [W-1:0] res_a,
   output logic [W-1:0] res_b,
   output logic         carry,
   output logic         ovf,
   output logic         done
);
   generate
      if (W < 2) begin : g_bad_width
         $error("mdu_seq: W must be at least 2");
      end
   endgenerate

   logic          accept, step, last, busy_q;
   mdu_op_e       op_q;
   logic [W-1:0]  opa_q, opb_q, hi_q, lo_q;
   logic [W-1:0]  m_hi, m_lo, d_hi, d_lo, nx_hi, nx_lo;
   logic          zero_div;

   mdu_seq_ctrl #(.W(W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .accept(accept), .step(step), .last(last),
      .busy(busy_q), .done(done)
   );

   mdu_mul_step #(.W(W)) u_mul (
      .hi(hi_q), .lo(lo_q), .mcand(opa_q), .hi_n(m_hi), .lo_n(m_lo)
   );

   mdu_div_step #(.W(W)) u_div (
      .rem(hi_q), .quo(lo_q), .dvsr(opb_q), .rem_n(d_hi), .quo_n(d_lo)
   );

   assign nx_hi    = (op_q == MDU_DIV) ? d_hi : m_hi;
   assign nx_lo    = (op_q == MDU_DIV) ? d_lo : m_lo;
   assign zero_div = (op_q == MDU_DIV) && (opb_q == '0);
   assign carry    = 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q  <= MDU_MUL;
         opa_q <= '0;
         opb_q <= '0;
         hi_q  <= '0;
         lo_q  <= '0;
      end else if (accept) begin
         op_q  <= op_div ? MDU_DIV : MDU_MUL;
         opa_q <= opnd_a;
         opb_q <= opnd_b;
         hi_q  <= '0;
         lo_q  <= op_div ? opnd_a : opnd_b;
      end else if (step) begin
         hi_q <= nx_hi;
         lo_q <= nx_lo;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_a <= '0;
         res_b <= '0;
         ovf   <= 1'b0;
      end else if (last) begin
         if (zero_div) begin
            res_a <= opa_q;
            res_b <= opb_q;
            ovf   <= 1'b1;
         end else begin
            res_a <= nx_lo;
            res_b <= nx_hi;
            ovf   <= (op_q == MDU_MUL) && (nx_hi != '0);
         end
      end
   end
endmodule

// File: rtl/mdu_seq_chk.sv
module mdu_seq_chk
   import muldiv_pkg::*;
#(
   parameter int W = 8,
   localparam int TW = $clog2(W + 2) + 1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         busy,
   input mdu_op_e      op_q,
   input logic [W-1:0] opa_q,
   input logic [W-1:0] opb_q,
   input logic [W-1:0] res_a,
   input logic [W-1:0] res_b,
   input logic         ovf,
   input logic         done
);
   logic [TW-1:0] trk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                trk_q <= '0;
      else if (start && !busy)   trk_q <= '0;
      else if (busy)             trk_q <= trk_q + 1'b1;
   end

   a_r6_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (trk_q == TW'(W)));
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(opa_q) && $stable(opb_q) && $stable(op_q)));
   a_r2_product: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == MDU_MUL) |-> ({res_b, res_a} == (2*W)'(opa_q) * (2*W)'(opb_q)));
   a_r3_mul_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == MDU_MUL) |-> (ovf == (res_b != '0)));
   a_r4_div_remainder: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == MDU_DIV && opb_q != '0) |-> (!ovf && res_b < opb_q));
   a_r5_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == MDU_DIV && opb_q == '0) |-> (ovf && res_a == opa_q && res_b == opb_q));
endmodule

bind mdu_seq mdu_seq_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_q),
   .op_q(op_q), .opa_q(opa_q), .opb_q(opb_q),
   .res_a(res_a), .res_b(res_b), .ovf(ovf), .done(done)
);

// File: tb/sim_mdu_seq.sv
`timescale 1ns/1ps
module sim_mdu_seq;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         op_div = 1'b0;
   logic [W-1:0] opnd_a = '0, opnd_b = '0;
   logic [W-1:0] res_a, res_b;
   logic         carry, ovf, done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   mdu_seq #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .res_a(res_a), .res_b(res_b),
      .carry(carry), .ovf(ovf), .done(done)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] expect_pack(input bit dv, input int a, input int b);
      int p;
      if (!dv) begin
         p = a * b;
         return {6'd0, 1'b0, (p > 255), p[15:0], 8'd0};
      end else if (b == 0) begin
         return {6'd0, 1'b0, 1'b1, b[7:0], a[7:0], 8'd0};
      end else begin
         p = a / b;
         return {6'd0, 1'b0, 1'b0, 8'((a % b)), p[7:0], 8'd0};
      end
   endfunction

   // Starts an operation, checks done is low before and high exactly in its slot.
   task automatic run_op(input string req, input bit dv, input int a, input int b);
      op_div = dv; opnd_a = a[W-1:0]; opnd_b = b[W-1:0]; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      repeat (W - 1) @(negedge clk);
      if (done !== 1'b0) check({req, " R6 early done"}, done, 0);
      @(negedge clk);
      check({req, " R6 done"}, done, 1);
      check(req, {6'd0, carry, ovf, res_b, res_a, 8'd0}, expect_pack(dv, a, b));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset outputs", {res_a, res_b, carry, ovf, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // corner cases
      run_op("R2 R3 mul 50xA0", 0, 'h50, 'hA0);
      run_op("R2 R3 mul FFxFF", 0, 255, 255);
      run_op("R2 R3 mul 0x0", 0, 0, 0);
      run_op("R2 R3 mul small", 0, 15, 17);
      run_op("R4 div 251/18", 1, 251, 18);
      run_op("R4 div 255/1", 1, 255, 1);
      run_op("R4 div 7/255", 1, 7, 255);
      run_op("R5 div by zero", 1, 'hA5, 0);

      // sweep
      for (int a = 0; a < 256; a += 7) begin
         for (int b = 0; b < 256; b += 11) begin
            run_op("R2 R3 mul sweep", 0, a, b);
            run_op("R4 R5 div sweep", 1, a, b);
         end
         run_op("R5 div zero sweep", 1, a, 0);
         run_op("R4 div by a", 1, 255, (a == 0) ? 1 : a);
      end

      // R7: start during a run is ignored
      op_div = 1'b0; opnd_a = 8'd200; opnd_b = 8'd3; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      op_div = 1'b1; opnd_a = 8'd9; opnd_b = 8'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (W - 5) @(negedge clk);
      check("R7 no early done", done, 0);
      @(negedge clk);
      check("R7 done on time", done, 1);
      check("R7 first op result", {ovf, res_b, res_a}, {1'b1, 16'd600});
      for (int i = 0; i < W + 4; i++) begin
         @(negedge clk);
         if (done !== 1'b0) check("R7 no second done", done, 0);
      end
      check("R7 results unchanged", {ovf, res_b, res_a}, {1'b1, 16'd600});

      // R8: results hold while inputs move
      run_op("R4 div 100/7", 1, 100, 7);
      for (int i = 0; i < 6; i++) begin
         opnd_a = 8'(i * 37); opnd_b = 8'(i * 53); op_div = i[0];
         @(negedge clk);
      end
      check("R8 hold after done", {done, ovf, res_b, res_a}, {1'b0, 1'b0, 8'd2, 8'd14});

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule